// File: doc/BRIEF.md
# Conversion Result Window Watchdog

This block sits beside a converter's result path and checks every finished sample against a programmable window. A sample is flagged when its raw code, before any alignment or offset is applied, lies above the upper bound or below the lower bound. Each sample carries a group marker that says whether it came from the regular group or the injected group. Software enables monitoring for each group on its own. It can also narrow the watch from all channels to one selected channel, and that one selection applies to both groups.

An event sets a sticky status flag, which stays set until software clears it. An interrupt line follows the flag while the interrupt enable is set. Both thresholds, the channel select and the control bits are written through simple write strobes. The thresholds and the channel select can be read back at the ports.

Top module: `awd_top`

## Requirements
- R1: After reset the status flag and interrupt are 0, the upper bound reads all ones (4095 at 12 bits), the lower bound reads 0, the channel select reads 0 and every control bit is clear.
- R2: A threshold write keeps only the low DATA_W bits of the 16-bit write data. The upper bound is written with hi_wr and the lower bound with lo_wr.
- R3: An event needs a sample strictly above the upper bound or strictly below the lower bound. A sample equal to either bound raises nothing.
- R4: Control bit 0 enables monitoring of regular samples (smp_inj=0) and bit 1 enables monitoring of injected samples (smp_inj=1). A sample whose group is not enabled never raises an event, and with both bits clear nothing is monitored.
- R5: When control bit 2 is set, only samples whose channel equals the channel select are monitored, and this holds for both groups. When bit 2 is clear, every channel is monitored.
- R6: A channel select write with a value above MAX_CHAN stores 0. Any other value is stored as written.
- R7: The status flag stays set until a write to flag_clr. If a clear and an event occur in the same cycle, the flag stays set.
- R8: The interrupt output equals the status flag ANDed with control bit 3.
- R9: An event on a sample presented at one clock edge shows on the flag right after that edge. A configuration write takes effect for samples presented on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hi_wr | input | 1 | Write strobe for the upper bound |
| lo_wr | input | 1 | Write strobe for the lower bound |
| thr_wdata | input | 16 | Threshold write data, masked to DATA_W |
| sel_wr | input | 1 | Write strobe for the channel select |
| sel_wdata | input | 5 | Channel select write data |
| ctl_wr | input | 1 | Write strobe for the control bits |
| ctl_wdata | input | 4 | Control bits: 0 regular, 1 injected, 2 single channel, 3 interrupt enable |
| flag_clr | input | 1 | Clears the status flag |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 12 | Raw sample code |
| smp_chan | input | 5 | Channel number of the sample |
| smp_inj | input | 1 | 1 for an injected sample, 0 for a regular sample |
| thr_hi_q | output | 12 | Upper bound readback |
| thr_lo_q | output | 12 | Lower bound readback |
| sel_chan_q | output | 5 | Channel select readback |
| wd_flag | output | 1 | Sticky status flag |
| wd_irq | output | 1 | Interrupt line |

## Verification
The bench builds the block with its default parameters: DATA_W=12, CHAN_W=5 and MAX_CHAN=17. With a 5-bit select and 17 as the highest channel, the codes 18 to 31 can be written, so the rejection path is exercised both by directed writes and by random ones. A 12-bit sample lets directed cases hit the bounds exactly and the full-scale codes 0 and 4095. The random phase reprograms the window, the group enables and the single-channel selection while samples keep arriving, and it compares the flag and interrupt with a model kept in the bench on every cycle.

// File: rtl/awd_pkg.sv
package awd_pkg;
  localparam int unsigned CMP_W = 16;

  typedef struct packed {
    logic irq_en;
    logic single;
    logic inj_en;
    logic reg_en;
  } awd_ctl_t;

  // true when the code lies strictly outside [lo, hi]
  function automatic logic outside_win(input logic [CMP_W-1:0] code,
                                       input logic [CMP_W-1:0] hi,
                                       input logic [CMP_W-1:0] lo);
    return (code > hi) || (code < lo);
  endfunction

  // true when a requested channel code is within the legal range
  function automatic logic chan_legal(input logic [CMP_W-1:0] req,
                                      input logic [CMP_W-1:0] max_ch);
    return req <= max_ch;
  endfunction
endpackage

// File: rtl/awd_cfg_regs.sv
module awd_cfg_regs
  import awd_pkg::*;
#(
  parameter int unsigned DATA_W   = 12,
  parameter int unsigned WDATA_W  = 16,
  parameter int unsigned CHAN_W   = 5,
  parameter int unsigned MAX_CHAN = 17
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hi_wr,
  input  logic               lo_wr,
  input  logic [WDATA_W-1:0] thr_wdata,
  input  logic               sel_wr,
  input  logic [CHAN_W-1:0]  sel_wdata,
  input  logic               ctl_wr,
  input  awd_ctl_t           ctl_wdata,
  output logic [DATA_W-1:0]  thr_hi,
  output logic [DATA_W-1:0]  thr_lo,
  output logic [CHAN_W-1:0]  sel_chan,
  output awd_ctl_t           ctl
);
  localparam logic [DATA_W-1:0] HI_RST = {DATA_W{1'b1}};

  logic              sel_ok;
  logic [CHAN_W-1:0] sel_next;

  assign sel_ok   = chan_legal(CMP_W'(sel_wdata), CMP_W'(MAX_CHAN));
  assign sel_next = sel_ok ? sel_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_hi   <= HI_RST;
      thr_lo   <= '0;
      sel_chan <= '0;
      ctl      <= '0;
    end else begin
      if (hi_wr)  thr_hi   <= thr_wdata[DATA_W-1:0];
      if (lo_wr)  thr_lo   <= thr_wdata[DATA_W-1:0];
      if (sel_wr) sel_chan <= sel_next;
      if (ctl_wr) ctl      <= ctl_wdata;
    end
  end
endmodule

// File: rtl/awd_window_cmp.sv
module awd_window_cmp
  import awd_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned CHAN_W = 5
) (
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  input  logic [CHAN_W-1:0] smp_chan,
  input  logic              smp_inj,
  input  logic [DATA_W-1:0] thr_hi,
  input  logic [DATA_W-1:0] thr_lo,
  input  logic [CHAN_W-1:0] sel_chan,
  input  awd_ctl_t          ctl,
  output logic              grp_on,
  output logic              chan_on,
  output logic              out_win,
  output logic              hit
);
  assign grp_on  = smp_inj ? ctl.inj_en : ctl.reg_en;
  assign chan_on = !ctl.single || (smp_chan == sel_chan);
  assign out_win = outside_win(CMP_W'(smp_data), CMP_W'(thr_hi), CMP_W'(thr_lo));
  assign hit     = smp_valid && grp_on && chan_on && out_win;
endmodule

// File: rtl/awd_event_latch.sv
module awd_event_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic clr,
  input  logic irq_en,
  output logic flag,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (hit) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  assign irq = flag && irq_en;
endmodule

// File: rtl/awd_top.sv
module awd_top
  import awd_pkg::*;
#(
  parameter int unsigned DATA_W   = 12,
  parameter int unsigned WDATA_W  = 16,
  parameter int unsigned CHAN_W   = 5,
  parameter int unsigned MAX_CHAN = 17
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hi_wr,
  input  logic               lo_wr,
  input  logic [WDATA_W-1:0] thr_wdata,
  input  logic               sel_wr,
  input  logic [CHAN_W-1:0]  sel_wdata,
  input  logic               ctl_wr,
  input  logic [3:0]         ctl_wdata,
  input  logic               flag_clr,
  input  logic               smp_valid,
  input  logic [DATA_W-1:0]  smp_data,
  input  logic [CHAN_W-1:0]  smp_chan,
  input  logic               smp_inj,
  output logic [DATA_W-1:0]  thr_hi_q,
  output logic [DATA_W-1:0]  thr_lo_q,
  output logic [CHAN_W-1:0]  sel_chan_q,
  output logic               wd_flag,
  output logic               wd_irq
);
  awd_ctl_t ctl_q;
  logic     grp_on, chan_on, out_win, wd_hit;

  awd_cfg_regs #(
    .DATA_W(DATA_W), .WDATA_W(WDATA_W), .CHAN_W(CHAN_W), .MAX_CHAN(MAX_CHAN)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .hi_wr(hi_wr), .lo_wr(lo_wr), .thr_wdata(thr_wdata),
    .sel_wr(sel_wr), .sel_wdata(sel_wdata),
    .ctl_wr(ctl_wr), .ctl_wdata(awd_ctl_t'(ctl_wdata)),
    .thr_hi(thr_hi_q), .thr_lo(thr_lo_q), .sel_chan(sel_chan_q), .ctl(ctl_q)
  );

  awd_window_cmp #(.DATA_W(DATA_W), .CHAN_W(CHAN_W)) u_cmp (
    .smp_valid(smp_valid), .smp_data(smp_data), .smp_chan(smp_chan),
    .smp_inj(smp_inj), .thr_hi(thr_hi_q), .thr_lo(thr_lo_q),
    .sel_chan(sel_chan_q), .ctl(ctl_q),
    .grp_on(grp_on), .chan_on(chan_on), .out_win(out_win), .hit(wd_hit)
  );

  awd_event_latch u_latch (
    .clk(clk), .rst_n(rst_n), .hit(wd_hit), .clr(flag_clr),
    .irq_en(ctl_q.irq_en), .flag(wd_flag), .irq(wd_irq)
  );
endmodule

// File: rtl/awd_chk.sv
module awd_chk #(
  parameter int unsigned CHAN_W   = 5,
  parameter int unsigned MAX_CHAN = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_valid,
  input logic              flag_clr,
  input logic              grp_on,
  input logic              chan_on,
  input logic              out_win,
  input logic              hit,
  input logic [CHAN_W-1:0] sel_chan_q,
  input logic              wd_flag,
  input logic              wd_irq
);
  AST_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> wd_flag);                                              // R9
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_flag && !flag_clr) |=> wd_flag);                           // R7
  AST_FLAG_NO_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wd_flag && !hit) |=> !wd_flag);                              // R3
  AST_HIT_NEEDS_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (smp_valid && grp_on && chan_on && out_win));          // R4
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wd_irq |-> wd_flag);                                           // R8
  AST_SEL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(sel_chan_q) <= MAX_CHAN);                                  // R6
endmodule

bind awd_top awd_chk #(.CHAN_W(CHAN_W), .MAX_CHAN(MAX_CHAN)) u_awd_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .flag_clr(flag_clr),
  .grp_on(grp_on), .chan_on(chan_on), .out_win(out_win), .hit(wd_hit),
  .sel_chan_q(sel_chan_q), .wd_flag(wd_flag), .wd_irq(wd_irq)
);

// File: tb/awd_top_tb.sv
module awd_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hi_wr = 0, lo_wr = 0, sel_wr = 0, ctl_wr = 0, flag_clr = 0;
  logic [15:0] thr_wdata = '0;
  logic [4:0]  sel_wdata = '0;
  logic [3:0]  ctl_wdata = '0;
  logic        smp_valid = 0, smp_inj = 0;
  logic [11:0] smp_data = '0;
  logic [4:0]  smp_chan = '0;
  logic [11:0] thr_hi_q, thr_lo_q;
  logic [4:0]  sel_chan_q;
  logic        wd_flag, wd_irq;

  int total = 0, bad = 0;
  bit done = 0;

  // bench model state
  logic [11:0] m_hi = 12'hFFF, m_lo = 12'h000;
  logic [4:0]  m_sel = '0;
  logic [3:0]  m_ctl = '0;
  logic        m_flag = 0;

  always #4 clk = ~clk;

  awd_top dut_i (
    .clk(clk), .rst_n(rst_n), .hi_wr(hi_wr), .lo_wr(lo_wr),
    .thr_wdata(thr_wdata), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .flag_clr(flag_clr),
    .smp_valid(smp_valid), .smp_data(smp_data), .smp_chan(smp_chan),
    .smp_inj(smp_inj), .thr_hi_q(thr_hi_q), .thr_lo_q(thr_lo_q),
    .sel_chan_q(sel_chan_q), .wd_flag(wd_flag), .wd_irq(wd_irq)
  );

  function automatic bit exp_event(bit v, bit inj, logic [4:0] ch, logic [11:0] d);
    bit grp = inj ? m_ctl[1] : m_ctl[0];
    bit chk = (m_ctl[2] == 0) || (ch == m_sel);
    return v && grp && chk && (int'(d) > int'(m_hi) || int'(d) < int'(m_lo));
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one clock: model update from current inputs, then compare after the edge
  task automatic cyc(string tag);
    bit ev = exp_event(smp_valid, smp_inj, smp_chan, smp_data);
    if (ev) m_flag = 1;
    else if (flag_clr) m_flag = 0;
    if (hi_wr) m_hi = thr_wdata[11:0];
    if (lo_wr) m_lo = thr_wdata[11:0];
    if (sel_wr) m_sel = (sel_wdata > 5'd17) ? 5'd0 : sel_wdata;
    if (ctl_wr) m_ctl = ctl_wdata;
    @(posedge clk);
    @(negedge clk);
    check({tag, " flag"}, wd_flag, m_flag);
    check({tag, " irq"}, wd_irq, m_flag & m_ctl[3]);
    hi_wr = 0; lo_wr = 0; sel_wr = 0; ctl_wr = 0; flag_clr = 0; smp_valid = 0;
  endtask

  task automatic sample(bit inj, logic [4:0] ch, logic [11:0] d, string tag);
    smp_valid = 1; smp_inj = inj; smp_chan = ch; smp_data = d;
    cyc(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 flag", wd_flag, 0);
    check("R1 irq", wd_irq, 0);
    check("R1 hi", thr_hi_q, 4095);
    check("R1 lo", thr_lo_q, 0);
    check("R1 sel", sel_chan_q, 0);
    sample(0, 3, 12'hFFF, "R1 R4 disabled at reset");

    // R2 masking
    hi_wr = 1; thr_wdata = 16'hF800; cyc("R2 write hi");
    check("R2 hi", thr_hi_q, 12'h800);
    lo_wr = 1; thr_wdata = 16'h1100; cyc("R2 write lo");
    check("R2 lo", thr_lo_q, 12'h100);

    // R3 boundaries with regular monitoring only
    ctl_wr = 1; ctl_wdata = 4'b0001; cyc("R4 ctl");
    sample(0, 1, 12'h800, "R3 equal hi");
    sample(0, 1, 12'h100, "R3 equal lo");
    sample(0, 1, 12'h801, "R3 R9 above hi");
    check("R8 irq off", wd_irq, 0);
    flag_clr = 1; cyc("R7 clear");
    sample(0, 1, 12'h0FF, "R3 below lo");
    flag_clr = 1; cyc("R7 clear2");
    sample(1, 1, 12'hFFF, "R4 injected disabled");

    // R4 injected with R8 interrupt
    ctl_wr = 1; ctl_wdata = 4'b1010; cyc("R4 ctl inj");
    sample(0, 1, 12'h000, "R4 regular disabled");
    sample(1, 1, 12'h000, "R4 R8 injected event");
    check("R8 irq on", wd_irq, 1);
    flag_clr = 1; smp_valid = 1; smp_inj = 1; smp_data = 12'hFFF; cyc("R7 clear vs event");
    check("R7 kept", wd_flag, 1);
    flag_clr = 1; cyc("R7 clear3");

    // R6 channel select
    sel_wr = 1; sel_wdata = 5'd20; cyc("R6 illegal");
    check("R6 sel cleared", sel_chan_q, 0);
    sel_wr = 1; sel_wdata = 5'd17; cyc("R6 max");
    check("R6 sel max", sel_chan_q, 17);
    sel_wr = 1; sel_wdata = 5'd5; cyc("R6 legal");
    check("R6 sel five", sel_chan_q, 5);

    // R5 single channel both groups
    ctl_wr = 1; ctl_wdata = 4'b0111; cyc("R5 ctl");
    sample(0, 4, 12'hFFF, "R5 other channel");
    sample(1, 6, 12'h000, "R5 other channel inj");
    sample(1, 5, 12'hFFF, "R5 selected inj");
    flag_clr = 1; cyc("R7 clear4");
    sample(0, 5, 12'h000, "R5 selected reg");
    flag_clr = 1; cyc("R7 clear5");
    ctl_wr = 1; ctl_wdata = 4'b0000; cyc("R4 off");
    sample(0, 5, 12'hFFF, "R4 none enabled");
    sample(1, 5, 12'h000, "R4 none enabled inj");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      if (r < 3) begin hi_wr = 1; thr_wdata = 16'($urandom); end
      else if (r < 6) begin lo_wr = 1; thr_wdata = 16'($urandom_range(0, 16'hFFFF)) >> 1; end
      else if (r < 9) begin sel_wr = 1; sel_wdata = 5'($urandom); end
      else if (r < 12) begin ctl_wr = 1; ctl_wdata = 4'($urandom); end
      if ($urandom_range(0, 9) == 0) flag_clr = 1;
      smp_valid = ($urandom_range(0, 3) != 0);
      smp_inj = 1'($urandom);
      smp_chan = ($urandom_range(0, 1) != 0) ? m_sel : 5'($urandom);
      smp_data = 12'($urandom);
      cyc("R3 R4 R5 R7 R8 random");
    end
    check("R2 R6 final hi", thr_hi_q, m_hi);
    check("R2 final lo", thr_lo_q, m_lo);
    check("R6 final sel", sel_chan_q, m_sel);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule